// File: doc/BRIEF.md
# UART FIFO Interrupt and DMA-Ready Controller

This block sits next to the transmit and receive FIFOs of a single UART channel. It does not hold any data. It watches the fill count of each FIFO, the receiver's line-error and timeout flags, a modem-change flag, and the pulses that mark characters carrying errors as they enter or leave the receive FIFO. From these inputs it builds a prioritized interrupt identification code and a single interrupt line. It also produces two active-low DMA handshake strobes, one for receive and one for transmit.

A 2-bit field selects one of four trigger levels. The levels are derived from the FIFO depth: one eighth, one quarter, one half, and depth minus one eighth. The same level is used for the receive-fill threshold and for the transmit free-space threshold.

The DMA strobes work in one of two ways:
- **Per-character mode.** Each strobe follows a simple empty or non-empty test.
- **Block mode.** This mode applies when FIFO mode and the DMA-mode select are both set. Each strobe asserts at the trigger level and releases only at the opposite extreme: receive releases when the FIFO is empty, and transmit releases when the FIFO is full.

All outputs are registered.

Top module: `uart_evt_ctrl`

## Requirements
- R1: While reset is held, the outputs are: `irq_id` = 4'h1, `irq` = 0, `rxrdy_n` = 1, `txrdy_n` = 1, `fifo_err` = 0.
- R2: `irq_id` reports only the highest pending source. The order and codes, from highest to lowest, are:
  - receive line status: 4'h6
  - receive data: 4'h4, or receive timeout: 4'hC
  - transmit empty: 4'h2
  - modem status: 4'h0
  - none pending: 4'h1
- R3: The receive-data source is pending when `ier[0]` is set and the receive count has reached the trigger level. The levels for `trig_sel` 0, 1, 2 and 3 are DEPTH/8, DEPTH/4, DEPTH/2 and DEPTH-DEPTH/8. With `fifo_en` low, the threshold is one character.
- R4: Receive timeout shares the receive-data level and is also enabled by `ier[0]`. It reports 4'hC when `rx_timeout` is high and the receive FIFO is not empty, but only if the receive-data condition is not met.
- R5: Transmit empty (enabled by `ier[1]`) becomes pending in two cases: when the transmit count falls to zero, or when `ier[1]` rises while the count is zero. The pending state clears on a `tx_write` pulse, or on an `isr_read` pulse while `irq_id` shows 4'h2.
- R6: `irq` is high exactly when `irq_id` is not 4'h1.
- R7: `fifo_err` is 1 while the number of `rx_push_err` pulses exceeds the number of `rx_pop_err` pulses.
- R8: Per-character mode applies when `dma_mode` is 0 or `fifo_en` is 0. In this mode:
  - `rxrdy_n` is low when the receive count is nonzero.
  - `txrdy_n` is low when the transmit count is zero.
- R9: In block mode, `rxrdy_n` goes low when the receive count reaches the trigger level or a timeout is pending with data present. It returns high only when the receive count is zero.
- R10: In block mode, `txrdy_n` goes low when the free space (DEPTH minus the transmit count) reaches the trigger level. It returns high only when the transmit FIFO is full.
- R11: The receive line status source (`rx_line_err`) is enabled by `ier[2]`, and the modem source (`modem_chg`) is enabled by `ier[3]`. A disabled source never appears in `irq_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| dma_mode | input | 1 | 0 selects per-character ready signalling, 1 selects block mode |
| trig_sel | input | 2 | Trigger level select |
| ier | input | 4 | Source enables: bit 0 receive data/timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem |
| rx_count | input | CW | Receive FIFO fill count |
| tx_count | input | CW | Transmit FIFO fill count |
| rx_line_err | input | 1 | Receiver line-status condition pending |
| rx_timeout | input | 1 | Receiver character timeout elapsed |
| modem_chg | input | 1 | Modem input change pending |
| rx_push_err | input | 1 | Pulse: a character with a parity, framing or break error entered the receive FIFO |
| rx_pop_err | input | 1 | Pulse: a character with an error left the receive FIFO |
| tx_write | input | 1 | Pulse: a character was written into the transmit FIFO |
| isr_read | input | 1 | Pulse: the interrupt status was read |
| irq_id | output | 4 | Highest pending interrupt code |
| irq | output | 1 | Interrupt request |
| rxrdy_n | output | 1 | Receive DMA ready, active low |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| fifo_err | output | 1 | At least one errored character is held in the receive FIFO |

## Verification
The bench builds the block with DEPTH = 16. This gives trigger levels of 2, 4, 8 and 14, so every count from empty to full can be swept for every trigger selection.

The sweeps check the receive threshold one count below and one count above each level. They also drive the block-mode strobes up to full and back down to empty, which exercises the hold region between the two thresholds in both directions.

Directed sequences stack every interrupt source at once and then remove them one at a time. This walks the full priority ladder, including the two ways the transmit-empty source can be cleared.

// File: rtl/uevt_pkg.sv
`timescale 1ns/1ps
package uevt_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // Trigger level for a 2-bit selection, scaled from the FIFO depth.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    int unsigned eighth;
    eighth = (depth / 8 == 0) ? 1 : depth / 8;
    case (sel)
      2'd0:    return eighth;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - eighth;
    endcase
  endfunction

endpackage

// File: rtl/uevt_trig.sv
`timescale 1ns/1ps
module uevt_trig #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_at_trig,
  output logic          tx_space_ok
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] lvl_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    assign lvl_tab[g] = CW'(uevt_pkg::trig_level(2'(g), DEPTH));
  end

  logic [CW-1:0] level;
  logic [CW-1:0] free_space;

  always_comb begin
    level       = lvl_tab[trig_sel];
    free_space  = DEPTH_C - tx_count;
    rx_at_trig  = fifo_en ? (rx_count >= level) : (rx_count != '0);
    tx_space_ok = (free_space >= level);
  end
endmodule

// File: rtl/uevt_errtrack.sv
`timescale 1ns/1ps
module uevt_errtrack #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push_err,
  input  logic pop_err,
  output logic fifo_err
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push_err && !pop_err)      cnt_d = cnt_q + 1'b1;
    else if (pop_err && !push_err) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      fifo_err <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      fifo_err <= (cnt_d != '0);
    end
  end

  p_push_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (push_err && !pop_err) |=> fifo_err);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    !(pop_err && !push_err && cnt_q == '0));
endmodule

// File: rtl/uevt_dma.sv
`timescale 1ns/1ps
module uevt_dma (
  input  logic clk,
  input  logic rst,
  input  logic fifo_en,
  input  logic dma_mode,
  input  logic rx_empty,
  input  logic rx_at_trig,
  input  logic timeout_live,
  input  logic tx_empty,
  input  logic tx_full,
  input  logic tx_space_ok,
  output logic rxrdy_n,
  output logic txrdy_n
);
  logic block_mode;
  logic rx_act_q, rx_act_d;
  logic tx_act_q, tx_act_d;

  always_comb begin
    block_mode = fifo_en && dma_mode;
    if (block_mode) begin
      if (rx_empty)                        rx_act_d = 1'b0;
      else if (rx_at_trig || timeout_live) rx_act_d = 1'b1;
      else                                 rx_act_d = rx_act_q;
      if (tx_full)                         tx_act_d = 1'b0;
      else if (tx_space_ok)                tx_act_d = 1'b1;
      else                                 tx_act_d = tx_act_q;
    end else begin
      rx_act_d = !rx_empty;
      tx_act_d = tx_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_act_q <= 1'b0;
      tx_act_q <= 1'b0;
    end else begin
      rx_act_q <= rx_act_d;
      tx_act_q <= tx_act_d;
    end
  end

  assign rxrdy_n = !rx_act_q;
  assign txrdy_n = !tx_act_q;

  p_rx_empty_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> rxrdy_n);

  p_tx_full_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode && tx_full) |=> txrdy_n);

  p_char_mode_tx_r8: assert property (@(posedge clk) disable iff (rst)
    (!dma_mode && tx_empty) |=> !txrdy_n);
endmodule

// File: rtl/uevt_prio.sv
`timescale 1ns/1ps
module uevt_prio
  import uevt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ier,
  input  logic       line_err,
  input  logic       rx_at_trig,
  input  logic       timeout_live,
  input  logic       tx_empty,
  input  logic       modem_chg,
  input  logic       tx_write,
  input  logic       isr_read,
  output logic [3:0] irq_id,
  output logic       irq
);
  irq_id_e id_q, id_d;
  logic    irq_q;
  logic    thre_pend_q, thre_pend_d;
  logic    empty_q, ier1_q;
  logic    thre_set;

  // Transmit-empty becomes pending on an edge: FIFO drains or enable rises.
  always_comb begin
    thre_set    = ier[1] && tx_empty && (!empty_q || !ier1_q);
    thre_pend_d = thre_pend_q;
    if (tx_write)                            thre_pend_d = 1'b0;
    else if (isr_read && id_q == ID_TXEMPTY) thre_pend_d = 1'b0;
    else if (thre_set)                       thre_pend_d = 1'b1;
  end

  always_comb begin
    if (ier[2] && line_err)          id_d = ID_LINE;
    else if (ier[0] && rx_at_trig)   id_d = ID_RXDATA;
    else if (ier[0] && timeout_live) id_d = ID_TIMEOUT;
    else if (ier[1] && thre_pend_q)  id_d = ID_TXEMPTY;
    else if (ier[3] && modem_chg)    id_d = ID_MODEM;
    else                             id_d = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q        <= ID_NONE;
      irq_q       <= 1'b0;
      thre_pend_q <= 1'b0;
      empty_q     <= 1'b1;
      ier1_q      <= 1'b0;
    end else begin
      id_q        <= id_d;
      irq_q       <= (id_d != ID_NONE);
      thre_pend_q <= thre_pend_d;
      empty_q     <= tx_empty;
      ier1_q      <= ier[1];
    end
  end

  assign irq_id = id_q;
  assign irq    = irq_q;

  p_irq_matches_id_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q == (id_q != ID_NONE));

  p_write_clears_thre_r5: assert property (@(posedge clk) disable iff (rst)
    tx_write |=> !thre_pend_q);

  p_line_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (ier[2] && line_err) |=> id_q == ID_LINE);

  p_masked_rx_r3: assert property (@(posedge clk) disable iff (rst)
    (ier == 4'b0000) |=> id_q == ID_NONE);
endmodule

// File: rtl/uart_evt_ctrl.sv
`timescale 1ns/1ps
module uart_evt_ctrl #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    trig_sel,
  input  logic [3:0]    ier,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_line_err,
  input  logic          rx_timeout,
  input  logic          modem_chg,
  input  logic          rx_push_err,
  input  logic          rx_pop_err,
  input  logic          tx_write,
  input  logic          isr_read,
  output logic [3:0]    irq_id,
  output logic          irq,
  output logic          rxrdy_n,
  output logic          txrdy_n,
  output logic          fifo_err
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic rx_at_trig, tx_space_ok;
  logic rx_empty, tx_empty, tx_full, timeout_live;

  assign rx_empty     = (rx_count == '0);
  assign tx_empty     = (tx_count == '0);
  assign tx_full      = (tx_count == DEPTH_C);
  assign timeout_live = rx_timeout && !rx_empty;

  uevt_trig #(.DEPTH(DEPTH), .CW(CW)) u_trig (
    .fifo_en     (fifo_en),
    .trig_sel    (trig_sel),
    .rx_count    (rx_count),
    .tx_count    (tx_count),
    .rx_at_trig  (rx_at_trig),
    .tx_space_ok (tx_space_ok)
  );

  uevt_prio u_prio (
    .clk          (clk),
    .rst          (rst),
    .ier          (ier),
    .line_err     (rx_line_err),
    .rx_at_trig   (rx_at_trig),
    .timeout_live (timeout_live),
    .tx_empty     (tx_empty),
    .modem_chg    (modem_chg),
    .tx_write     (tx_write),
    .isr_read     (isr_read),
    .irq_id       (irq_id),
    .irq          (irq)
  );

  uevt_dma u_dma (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .dma_mode     (dma_mode),
    .rx_empty     (rx_empty),
    .rx_at_trig   (rx_at_trig),
    .timeout_live (timeout_live),
    .tx_empty     (tx_empty),
    .tx_full      (tx_full),
    .tx_space_ok  (tx_space_ok),
    .rxrdy_n      (rxrdy_n),
    .txrdy_n      (txrdy_n)
  );

  uevt_errtrack #(.DEPTH(DEPTH), .CW(CW)) u_err (
    .clk      (clk),
    .rst      (rst),
    .push_err (rx_push_err),
    .pop_err  (rx_pop_err),
    .fifo_err (fifo_err)
  );
endmodule

// File: tb/uart_evt_ctrl_test.sv
`timescale 1ns/1ps
module uart_evt_ctrl_test;
  localparam int D  = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0, dma_mode = 1'b0;
  logic [1:0]    trig_sel = 2'd0;
  logic [3:0]    ier = 4'h0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic          rx_line_err = 1'b0, rx_timeout = 1'b0, modem_chg = 1'b0;
  logic          rx_push_err = 1'b0, rx_pop_err = 1'b0, tx_write = 1'b0, isr_read = 1'b0;
  logic [3:0]    irq_id;
  logic          irq, rxrdy_n, txrdy_n, fifo_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_evt_ctrl #(.DEPTH(D), .CW(CW)) uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_sel(trig_sel),
    .ier(ier), .rx_count(rx_count), .tx_count(tx_count), .rx_line_err(rx_line_err),
    .rx_timeout(rx_timeout), .modem_chg(modem_chg), .rx_push_err(rx_push_err),
    .rx_pop_err(rx_pop_err), .tx_write(tx_write), .isr_read(isr_read),
    .irq_id(irq_id), .irq(irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .fifo_err(fifo_err)
  );

  function automatic int lvl(input int sel);
    int e;
    e = D / 8;
    if (sel == 0) return e;
    if (sel == 1) return D / 4;
    if (sel == 2) return D / 2;
    return D - e;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic pulse_read();
    isr_read = 1'b1; @(posedge clk); #1; isr_read = 1'b0;
  endtask

  task automatic pulse_write();
    tx_write = 1'b1; @(posedge clk); #1; tx_write = 1'b0;
  endtask

  task automatic pulse_err(input bit push);
    if (push) rx_push_err = 1'b1; else rx_pop_err = 1'b1;
    @(posedge clk); #1;
    rx_push_err = 1'b0; rx_pop_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit act;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq_id", irq_id, 1);
    chk("R1 irq", irq, 0);
    chk("R1 rxrdy_n", rxrdy_n, 1);
    chk("R1 txrdy_n", txrdy_n, 1);
    chk("R1 fifo_err", fifo_err, 0);
    rst = 1'b0;
    settle();

    // R3/R6/R8 receive threshold sweep, per-character DMA
    fifo_en = 1'b1; ier = 4'h1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int c = 0; c <= D; c++) begin
        rx_count = CW'(c);
        settle();
        chk("R3 rx trigger", irq_id, (c >= lvl(s)) ? 4 : 1);
        chk("R6 irq", irq, (c >= lvl(s)) ? 1 : 0);
        chk("R8 rxrdy char", rxrdy_n, (c == 0) ? 1 : 0);
      end
    end

    // R3 non-FIFO threshold is one character
    fifo_en = 1'b0; trig_sel = 2'd3;
    for (int c = 0; c <= 2; c++) begin
      rx_count = CW'(c);
      settle();
      chk("R3 nonfifo", irq_id, (c >= 1) ? 4 : 1);
    end

    // R4 timeout shares level with data
    fifo_en = 1'b1; rx_timeout = 1'b1;
    for (int c = 0; c <= D; c++) begin
      rx_count = CW'(c);
      settle();
      chk("R4 timeout", irq_id, (c >= lvl(3)) ? 4 : ((c != 0) ? 12 : 1));
    end
    ier = 4'h0; rx_count = 5'd3;
    settle();
    chk("R4 gated", irq_id, 1);
    ier = 4'h1; rx_timeout = 1'b0; rx_count = '0;
    settle();

    // R2 priority ladder (R5 read-clear included)
    ier = 4'hF; rx_count = CW'(D); rx_timeout = 1'b1; rx_line_err = 1'b1; modem_chg = 1'b1;
    settle();
    chk("R2 line top", irq_id, 6);
    rx_line_err = 1'b0; settle();
    chk("R2 rx data", irq_id, 4);
    rx_count = 5'd3; settle();
    chk("R2 timeout", irq_id, 12);
    rx_timeout = 1'b0; rx_count = '0; settle();
    chk("R2 tx empty", irq_id, 2);
    pulse_read(); settle();
    chk("R5 read clears", irq_id, 0);
    modem_chg = 1'b0; settle();
    chk("R2 none", irq_id, 1);
    chk("R6 irq low", irq, 0);

    // R5 transmit empty via write and re-arm, R8 tx per-character
    ier = 4'h0; settle();
    ier = 4'h2; settle();
    chk("R5 enable edge", irq_id, 2);
    tx_count = 5'd1; pulse_write(); settle();
    chk("R5 write clears", irq_id, 1);
    chk("R8 txrdy busy", txrdy_n, 1);
    tx_count = '0; settle();
    chk("R5 drain sets", irq_id, 2);
    chk("R8 txrdy ready", txrdy_n, 0);
    ier = 4'h0; settle();
    chk("R5 gated", irq_id, 1);

    // R11 gating of line and modem
    rx_line_err = 1'b1; settle();
    chk("R11 line masked", irq_id, 1);
    ier = 4'h4; settle();
    chk("R11 line enabled", irq_id, 6);
    rx_line_err = 1'b0; modem_chg = 1'b1; settle();
    chk("R11 modem masked", irq_id, 1);
    ier = 4'h8; settle();
    chk("R11 modem enabled", irq_id, 0);
    modem_chg = 1'b0; ier = 4'h0; settle();

    // R7 error tracking
    pulse_err(1'b1); pulse_err(1'b1); settle();
    chk("R7 two errors", fifo_err, 1);
    pulse_err(1'b0); settle();
    chk("R7 one left", fifo_err, 1);
    pulse_err(1'b0); settle();
    chk("R7 drained", fifo_err, 0);

    // R9 block-mode receive strobe
    dma_mode = 1'b1; trig_sel = 2'd1; rx_count = '0; settle();
    act = 1'b0;
    for (int c = 0; c <= D; c++) begin
      rx_count = CW'(c); settle();
      if (c == 0) act = 1'b0; else if (c >= lvl(1)) act = 1'b1;
      chk("R9 rx up", rxrdy_n, act ? 0 : 1);
    end
    for (int c = D; c >= 0; c--) begin
      rx_count = CW'(c); settle();
      if (c == 0) act = 1'b0; else if (c >= lvl(1)) act = 1'b1;
      chk("R9 rx down", rxrdy_n, act ? 0 : 1);
    end
    rx_count = 5'd2; rx_timeout = 1'b1; settle();
    chk("R9 timeout", rxrdy_n, 0);
    rx_timeout = 1'b0; settle();
    chk("R9 hold", rxrdy_n, 0);
    rx_count = '0; settle();
    chk("R9 empty", rxrdy_n, 1);

    // R10 block-mode transmit strobe
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s); tx_count = '0; settle();
      act = 1'b1;
      for (int c = 0; c <= D; c++) begin
        tx_count = CW'(c); settle();
        if (c == D) act = 1'b0; else if (D - c >= lvl(s)) act = 1'b1;
        chk("R10 tx up", txrdy_n, act ? 0 : 1);
      end
      for (int c = D; c >= 0; c--) begin
        tx_count = CW'(c); settle();
        if (c == D) act = 1'b0; else if (D - c >= lvl(s)) act = 1'b1;
        chk("R10 tx down", txrdy_n, act ? 0 : 1);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule